// File: doc/BRIEF.md
# Pilot Phase Drift Estimator

This block estimates the residual carrier frequency offset and the sampling clock offset of a multicarrier receiver from scattered pilot tones. An upstream stage extracts pilots and converts each one to a phase word. For every pilot the block keeps the phase last seen on that pilot slot. When the same slot comes back exactly one repetition period later, the block subtracts the stored phase from the new one. The repetition period is 2 symbols in the interleaved-permutation zone and 6 symbols in the adjacent-permutation zone.

The differential phases are summed separately for the lower and the upper half of the band, and separately per zone. A frame-close strobe starts the per-zone reduction. The common rotation (intercept) is the mean of the two half means, and it tracks the carrier offset. The difference between the upper and lower half means (slope) tracks the clock offset. The per-zone results are averaged into one frame estimate, which stays on the outputs until the next frame closes. A four-frame moving average gives a smoothed copy, qualified by its own valid flag.

Top module: `pilot_fo_estimator`

## Requirements
- R1: A pilot on slot k produces a differential phase, equal to its phase minus the stored phase of slot k modulo 2^PW, only if slot k was last seen in the same frame, in the same zone (pil_amc equal), exactly P_PUSC (pil_amc=0) or P_AMC (pil_amc=1) symbols earlier (pil_sym difference modulo 2^SYW). Otherwise the pilot contributes nothing. In every case the pilot's phase, symbol and zone become the new stored values for slot k.
- R2: For a usable zone with N differentials in each half, the zone intercept is (sum_low + sum_high) / (2N) and the zone slope is (sum_high - sum_low) / N, both truncated toward zero.
- R3: A zone is usable only when its lower and upper counts are equal and nonzero. half_mismatch, updated together with est_strobe, is 1 when either zone has unequal counts.
- R4: When both zones are usable, the frame intercept and frame slope are (a + b) >>> 1 of the two zone values (floor). When one zone is usable, they are that zone's values.
- R5: Each frame_end leads to exactly one single-cycle est_strobe. est_fresh is high with it exactly when at least one zone is usable. frame_int and frame_slope change only on a fresh strobe and are otherwise held.
- R6: frame_end discards all stored pilot phases, so no differential spans two frames. frame_end never coincides with pil_valid.
- R7: avg_int and avg_slope equal the floor of the sum of the last 4 fresh frame estimates divided by 4. avg_valid stays low, and both averages read zero, until 4 fresh estimates have been made since reset. avg_valid then stays high.
- R8: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pil_valid | input | 1 | Pilot sample present |
| pil_slot | input | $clog2(NSLOT) (5) | Pilot slot identifier |
| pil_phase | input | PW (12) | Pilot phase, full circle = 2^PW |
| pil_upper | input | 1 | 1 = pilot in upper band half |
| pil_sym | input | SYW (8) | Symbol index within the frame |
| pil_amc | input | 1 | 0 = interleaved zone (period P_PUSC), 1 = adjacent zone (period P_AMC) |
| frame_end | input | 1 | Close the frame and start the reduction |
| est_strobe | output | 1 | One-cycle pulse when a frame result is posted |
| est_fresh | output | 1 | With est_strobe: a new estimate was made |
| half_mismatch | output | 1 | Unequal half counts seen in the last frame |
| frame_int | output | PW (12) | Frame intercept, signed |
| frame_slope | output | PW+1 (13) | Frame slope, signed |
| avg_int | output | PW (12) | Smoothed intercept, signed |
| avg_slope | output | PW+1 (13) | Smoothed slope, signed |
| avg_valid | output | 1 | Smoothing window full |

## Verification
A corrupted slot memory or a wrong period compare turns into a wrong count or a wrong sum. Within one frame close this appears as a wrong est_fresh, a wrong half_mismatch or a wrong frame_int/frame_slope. An error in the divider sign handling or in the zone selection shows up at the first strobe whose zone sums are negative or whose zones differ. A fault in the smoothing history shows on avg_valid at the fourth fresh frame, or on avg_int/avg_slope at every later strobe.

// File: rtl/pfe_pkg.sv
// Shared types for the pilot phase drift estimator.
package pfe_pkg;
    // Reduction sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RUN,
        ST_DONE
    } pfe_state_e;

    // Number of zones tracked (interleaved and adjacent permutation).
    localparam int ZONES = 2;
endpackage

// File: rtl/pfe_pilot_diff.sv
// Per-slot phase memory and time differencing.
// Assumes pil_valid and frame_end never coincide. The output is registered
// one cycle after the pilot.
module pfe_pilot_diff #(
    parameter int PW     = 12,
    parameter int SLW    = 5,
    parameter int SYW    = 8,
    parameter int P_PUSC = 2,
    parameter int P_AMC  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_end,
    input  logic                 pil_valid,
    input  logic [SLW-1:0]       pil_slot,
    input  logic [PW-1:0]        pil_phase,
    input  logic                 pil_upper,
    input  logic [SYW-1:0]       pil_sym,
    input  logic                 pil_amc,
    output logic                 d_valid,
    output logic signed [PW-1:0] d_val,
    output logic                 d_upper,
    output logic                 d_amc
);
    localparam int NSLOT = 1 << SLW;

    logic [PW-1:0]    ph_mem  [NSLOT];
    logic [SYW-1:0]   sym_mem [NSLOT];
    logic [NSLOT-1:0] amc_mem;
    logic [NSLOT-1:0] vld_mem;
    logic [SYW-1:0]   gap;
    logic [SYW-1:0]   want;
    logic             hit;

    // Decide whether this pilot pairs with the stored one.
    always_comb begin
        gap  = pil_sym - sym_mem[pil_slot];
        want = pil_amc ? SYW'(P_AMC) : SYW'(P_PUSC);
        hit  = vld_mem[pil_slot] && (amc_mem[pil_slot] == pil_amc) && (gap == want);
    end

    // Store the latest phase, symbol and zone of each slot.
    always_ff @(posedge clk) begin
        if (pil_valid) begin
            ph_mem[pil_slot]  <= pil_phase;
            sym_mem[pil_slot] <= pil_sym;
            amc_mem[pil_slot] <= pil_amc;
        end
    end

    // Slot validity and the registered differential output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_mem <= '0;
            d_valid <= 1'b0;
            d_val   <= '0;
            d_upper <= 1'b0;
            d_amc   <= 1'b0;
        end else begin
            d_valid <= 1'b0;
            if (frame_end) begin
                vld_mem <= '0;
            end else if (pil_valid) begin
                vld_mem[pil_slot] <= 1'b1;
                d_valid <= hit;
                d_val   <= pil_phase - ph_mem[pil_slot];
                d_upper <= pil_upper;
                d_amc   <= pil_amc;
            end
        end
    end
endmodule

// File: rtl/pfe_half_accum.sv
// Per-zone, per-half sums and counts of differential phases.
// frame_end copies the running totals to the snapshot and clears them.
// Assumes at most 2^CW-1 differentials per half per frame.
module pfe_half_accum #(
    parameter int PW = 12,
    parameter int CW = 7,
    parameter int ZN = 2,
    localparam int AW = PW + CW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_end,
    input  logic                 d_valid,
    input  logic signed [PW-1:0] d_val,
    input  logic                 d_upper,
    input  logic                 d_amc,
    output logic signed [AW-1:0] lo_sum [ZN],
    output logic signed [AW-1:0] hi_sum [ZN],
    output logic [CW-1:0]        lo_cnt [ZN],
    output logic [CW-1:0]        hi_cnt [ZN]
);
    for (genvar z = 0; z < ZN; z++) begin : g_zone
        logic signed [AW-1:0] run_lo, run_hi;
        logic [CW-1:0]        run_nlo, run_nhi;
        logic                 mine;

        assign mine = d_valid && (d_amc == 1'(z));

        // Accumulate this zone's pilots and snapshot at frame close.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run_lo <= '0; run_hi <= '0; run_nlo <= '0; run_nhi <= '0;
                lo_sum[z] <= '0; hi_sum[z] <= '0; lo_cnt[z] <= '0; hi_cnt[z] <= '0;
            end else if (frame_end) begin
                lo_sum[z] <= run_lo; hi_sum[z] <= run_hi;
                lo_cnt[z] <= run_nlo; hi_cnt[z] <= run_nhi;
                run_lo <= '0; run_hi <= '0; run_nlo <= '0; run_nhi <= '0;
            end else if (mine && d_upper) begin
                run_hi  <= run_hi + d_val;
                run_nhi <= run_nhi + CW'(1);
            end else if (mine) begin
                run_lo  <= run_lo + d_val;
                run_nlo <= run_nlo + CW'(1);
            end
        end
    end
endmodule

// File: rtl/pfe_divider.sv
// Unsigned restoring divider, one quotient bit per cycle.
// done pulses NW+1 cycles after start. A zero divisor gives all ones.
module pfe_divider #(
    parameter int NW = 20,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [NW-1:0] quot
);
    localparam int CNTW = $clog2(NW + 1);

    logic [NW-1:0]   dvd;
    logic [DW-1:0]   dvs;
    logic [DW-1:0]   rem;
    logic [CNTW-1:0] cnt;
    logic            busy;
    logic [DW:0]     trial;
    logic            fits;

    // Bring down the next dividend bit and test it against the divisor.
    always_comb begin
        trial = {rem, dvd[NW-1]};
        fits  = trial >= {1'b0, dvs};
    end

    // Iterate through the shift-subtract steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd <= '0; dvs <= '0; rem <= '0; quot <= '0;
            cnt <= '0; busy <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                dvd  <= dividend;
                dvs  <= divisor;
                rem  <= '0;
                quot <= '0;
                cnt  <= CNTW'(NW);
                busy <= 1'b1;
            end else if (busy) begin
                rem  <= fits ? DW'(trial - {1'b0, dvs}) : trial[DW-1:0];
                quot <= {quot[NW-2:0], fits};
                dvd  <= dvd << 1;
                cnt  <= cnt - CNTW'(1);
                if (cnt == CNTW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pfe_smoother.sv
// Moving average over the last 2^LOG2 pushed values (floor). It reads zero
// until the window has been filled once.
module pfe_smoother #(
    parameter int W    = 12,
    parameter int LOG2 = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] avg,
    output logic                full
);
    localparam int N = 1 << LOG2;

    logic signed [W-1:0]      hist [N];
    logic [LOG2:0]            fill;
    logic signed [W+LOG2-1:0] sum;

    // Shift the history and count entries up to the window size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) hist[i] <= '0;
            fill <= '0;
        end else if (push) begin
            hist[0] <= din;
            for (int i = 1; i < N; i++) hist[i] <= hist[i-1];
            if (fill != (LOG2+1)'(N)) fill <= fill + (LOG2+1)'(1);
        end
    end

    // Sum the window and scale it by the window size.
    always_comb begin
        sum = '0;
        for (int i = 0; i < N; i++) sum = sum + hist[i];
        full = (fill == (LOG2+1)'(N));
        avg  = full ? sum[W+LOG2-1:LOG2] : '0;
    end
endmodule

// File: rtl/pilot_fo_estimator.sv
// Top level: differences pilot phases per slot, accumulates them per zone
// and band half, then at frame close runs four divisions on one shared
// divider (intercept and slope for each zone), combines the zones and
// smooths the result. Assumes frame_end comes at least 3 cycles after the
// last pilot and not while a reduction is still running.
module pilot_fo_estimator #(
    parameter int PW       = 12,
    parameter int NSLOT    = 32,
    parameter int SYW      = 8,
    parameter int MAXP     = 64,
    parameter int P_PUSC   = 2,
    parameter int P_AMC    = 6,
    parameter int AVG_LOG2 = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pil_valid,
    input  logic [$clog2(NSLOT)-1:0] pil_slot,
    input  logic [PW-1:0]            pil_phase,
    input  logic                     pil_upper,
    input  logic [SYW-1:0]           pil_sym,
    input  logic                     pil_amc,
    input  logic                     frame_end,
    output logic                     est_strobe,
    output logic                     est_fresh,
    output logic                     half_mismatch,
    output logic signed [PW-1:0]     frame_int,
    output logic signed [PW:0]       frame_slope,
    output logic signed [PW-1:0]     avg_int,
    output logic signed [PW:0]       avg_slope,
    output logic                     avg_valid
);
    import pfe_pkg::*;

    localparam int SLW = $clog2(NSLOT);
    localparam int CW  = $clog2(MAXP + 1);
    localparam int AW  = PW + CW;
    localparam int SW  = AW + 1;
    localparam int DW  = CW + 1;

    logic                 d_valid, d_upper, d_amc;
    logic signed [PW-1:0] d_val;
    logic signed [AW-1:0] lo_sum [ZONES];
    logic signed [AW-1:0] hi_sum [ZONES];
    logic [CW-1:0]        lo_cnt [ZONES];
    logic [CW-1:0]        hi_cnt [ZONES];

    pfe_state_e           state;
    logic [1:0]           job;
    logic                 neg_q;
    logic signed [SW-1:0] q_res [4];
    logic                 div_done;
    logic [SW-1:0]        div_quot;

    logic                 zsel, kind;
    logic signed [SW-1:0] lo_x, hi_x, num;
    logic [SW-1:0]        num_mag;
    logic [DW-1:0]        dvs;
    logic [ZONES-1:0]     usable;
    logic                 mism;
    logic signed [SW:0]   both_i, both_s, pick_i, pick_s;
    logic                 push;

    pfe_pilot_diff #(.PW(PW), .SLW(SLW), .SYW(SYW), .P_PUSC(P_PUSC), .P_AMC(P_AMC)) u_diff (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .pil_valid(pil_valid),
        .pil_slot(pil_slot), .pil_phase(pil_phase), .pil_upper(pil_upper),
        .pil_sym(pil_sym), .pil_amc(pil_amc), .d_valid(d_valid), .d_val(d_val),
        .d_upper(d_upper), .d_amc(d_amc)
    );

    pfe_half_accum #(.PW(PW), .CW(CW), .ZN(ZONES)) u_acc (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .d_valid(d_valid),
        .d_val(d_val), .d_upper(d_upper), .d_amc(d_amc),
        .lo_sum(lo_sum), .hi_sum(hi_sum), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt)
    );

    // Operands of the current job: job = {zone, 0 intercept / 1 slope}.
    always_comb begin
        zsel    = job[1];
        kind    = job[0];
        lo_x    = lo_sum[zsel];
        hi_x    = hi_sum[zsel];
        num     = kind ? (hi_x - lo_x) : (hi_x + lo_x);
        num_mag = num[SW-1] ? SW'(-num) : SW'(num);
        dvs     = kind ? {1'b0, lo_cnt[zsel]} : {lo_cnt[zsel], 1'b0};
    end

    pfe_divider #(.NW(SW), .DW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .start(state == ST_LOAD), .dividend(num_mag),
        .divisor(dvs), .done(div_done), .quot(div_quot)
    );

    // Zone usability and the combination of the zone results.
    always_comb begin
        for (int z = 0; z < ZONES; z++)
            usable[z] = (lo_cnt[z] == hi_cnt[z]) && (lo_cnt[z] != '0);
        mism   = (lo_cnt[0] != hi_cnt[0]) || (lo_cnt[1] != hi_cnt[1]);
        both_i = q_res[0] + q_res[2];
        both_s = q_res[1] + q_res[3];
        if (usable[0] && usable[1]) begin
            pick_i = both_i >>> 1;
            pick_s = both_s >>> 1;
        end else if (usable[0]) begin
            pick_i = q_res[0];
            pick_s = q_res[1];
        end else begin
            pick_i = q_res[2];
            pick_s = q_res[3];
        end
        push = (state == ST_DONE) && (usable != '0);
    end

    // Sequence the four divisions and post the frame result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; job <= '0; neg_q <= 1'b0;
            for (int j = 0; j < 4; j++) q_res[j] <= '0;
            est_strobe <= 1'b0; est_fresh <= 1'b0; half_mismatch <= 1'b0;
            frame_int <= '0; frame_slope <= '0;
        end else begin
            est_strobe <= 1'b0;
            est_fresh  <= 1'b0;
            case (state)
                ST_IDLE: if (frame_end) begin
                    state <= ST_LOAD;
                    job   <= '0;
                end
                ST_LOAD: begin
                    neg_q <= num[SW-1];
                    state <= ST_RUN;
                end
                ST_RUN: if (div_done) begin
                    q_res[job] <= neg_q ? SW'(-div_quot) : SW'(div_quot);
                    if (job == 2'd3) state <= ST_DONE;
                    else begin
                        job   <= job + 2'd1;
                        state <= ST_LOAD;
                    end
                end
                default: begin
                    est_strobe    <= 1'b1;
                    est_fresh     <= push;
                    half_mismatch <= mism;
                    if (push) begin
                        frame_int   <= PW'(pick_i);
                        frame_slope <= (PW+1)'(pick_s);
                    end
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    pfe_smoother #(.W(PW), .LOG2(AVG_LOG2)) u_sm_int (
        .clk(clk), .rst_n(rst_n), .push(push), .din(PW'(pick_i)),
        .avg(avg_int), .full(avg_valid)
    );

    pfe_smoother #(.W(PW+1), .LOG2(AVG_LOG2)) u_sm_slope (
        .clk(clk), .rst_n(rst_n), .push(push), .din((PW+1)'(pick_s)),
        .avg(avg_slope), .full()
    );
endmodule

// File: rtl/pilot_fo_estimator_chk.sv
// Port-level properties of the estimator, bound to every instance.
module pilot_fo_estimator_chk #(
    parameter int PW = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pil_valid,
    input logic                 frame_end,
    input logic                 est_strobe,
    input logic                 est_fresh,
    input logic                 half_mismatch,
    input logic signed [PW-1:0] frame_int,
    input logic signed [PW:0]   frame_slope,
    input logic signed [PW-1:0] avg_int,
    input logic signed [PW:0]   avg_slope,
    input logic                 avg_valid
);
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        est_strobe |=> !est_strobe);

    a_r5_fresh_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        est_fresh |-> est_strobe);

    a_r5_int_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_int) |-> est_fresh);

    a_r5_slope_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_slope) |-> est_fresh);

    a_r3_mismatch_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(half_mismatch) |-> est_strobe);

    a_r7_zero_until_full: assert property (@(posedge clk) disable iff (!rst_n)
        !avg_valid |-> (avg_int == '0) && (avg_slope == '0));

    a_r7_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |=> avg_valid);

    a_r6_no_pilot_at_close: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !pil_valid);
endmodule

bind pilot_fo_estimator pilot_fo_estimator_chk #(.PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pil_valid(pil_valid), .frame_end(frame_end),
    .est_strobe(est_strobe), .est_fresh(est_fresh), .half_mismatch(half_mismatch),
    .frame_int(frame_int), .frame_slope(frame_slope), .avg_int(avg_int),
    .avg_slope(avg_slope), .avg_valid(avg_valid)
);

// File: tb/sim_pilot_fo_estimator.sv
// Bench: directed corner frames plus seeded random frames, checked against
// a behavioural model kept in the bench.
module sim_pilot_fo_estimator;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pil_valid = 1'b0;
    logic [4:0]        pil_slot = '0;
    logic [11:0]       pil_phase = '0;
    logic              pil_upper = 1'b0;
    logic [7:0]        pil_sym = '0;
    logic              pil_amc = 1'b0;
    logic              frame_end = 1'b0;
    logic              est_strobe, est_fresh, half_mismatch, avg_valid;
    logic signed [11:0] frame_int, avg_int;
    logic signed [12:0] frame_slope, avg_slope;

    int n_tests = 0;
    int n_fail  = 0;

    // Model state.
    int m_ph [32];
    int m_sym [32];
    bit m_amc [32];
    bit m_vld [32];
    int s_lo [2];
    int s_hi [2];
    int c_lo [2];
    int c_hi [2];
    int h_i [4];
    int h_s [4];
    int n_fresh = 0;
    int exp_fi = 0;
    int exp_fs = 0;

    pilot_fo_estimator u0 (
        .clk(clk), .rst_n(rst_n), .pil_valid(pil_valid), .pil_slot(pil_slot),
        .pil_phase(pil_phase), .pil_upper(pil_upper), .pil_sym(pil_sym),
        .pil_amc(pil_amc), .frame_end(frame_end), .est_strobe(est_strobe),
        .est_fresh(est_fresh), .half_mismatch(half_mismatch), .frame_int(frame_int),
        .frame_slope(frame_slope), .avg_int(avg_int), .avg_slope(avg_slope),
        .avg_valid(avg_valid)
    );

    always #5 clk = ~clk;

    function automatic int wdiff(int a, int b);
        logic signed [11:0] d;
        d = 12'(a - b);
        return int'(d);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic send(int slot, int phase, bit upper, int sym, bit amc);
        int d;
        @(negedge clk);
        pil_valid = 1'b1;
        pil_slot  = 5'(slot);
        pil_phase = 12'(phase);
        pil_upper = upper;
        pil_sym   = 8'(sym);
        pil_amc   = amc;
        if (m_vld[slot] && m_amc[slot] == amc &&
            ((sym - m_sym[slot]) & 255) == (amc ? 6 : 2)) begin
            d = wdiff(phase, m_ph[slot]);
            if (upper) begin s_hi[amc] += d; c_hi[amc]++; end
            else begin s_lo[amc] += d; c_lo[amc]++; end
        end
        m_ph[slot] = phase & 4095; m_sym[slot] = sym & 255;
        m_amc[slot] = amc; m_vld[slot] = 1'b1;
    endtask

    task automatic close_frame(string tag);
        bit u [2];
        int zi [2];
        int zs [2];
        bit mm, fresh;
        int wait_n, si, ss;
        @(negedge clk);
        pil_valid = 1'b0;
        repeat (3) @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        for (int k = 0; k < 32; k++) m_vld[k] = 1'b0;
        for (int z = 0; z < 2; z++) begin
            u[z] = (c_lo[z] == c_hi[z]) && (c_lo[z] != 0);
            zi[z] = u[z] ? (s_lo[z] + s_hi[z]) / (2 * c_lo[z]) : 0;
            zs[z] = u[z] ? (s_hi[z] - s_lo[z]) / c_lo[z] : 0;
        end
        mm = (c_lo[0] != c_hi[0]) || (c_lo[1] != c_hi[1]);
        fresh = u[0] || u[1];
        if (u[0] && u[1]) begin
            exp_fi = (zi[0] + zi[1]) >>> 1;
            exp_fs = (zs[0] + zs[1]) >>> 1;
        end else if (u[0]) begin
            exp_fi = zi[0]; exp_fs = zs[0];
        end else if (u[1]) begin
            exp_fi = zi[1]; exp_fs = zs[1];
        end
        if (fresh) begin
            for (int k = 3; k > 0; k--) begin h_i[k] = h_i[k-1]; h_s[k] = h_s[k-1]; end
            h_i[0] = exp_fi; h_s[0] = exp_fs;
            n_fresh++;
        end
        si = 0; ss = 0;
        for (int k = 0; k < 4; k++) begin si += h_i[k]; ss += h_s[k]; end
        wait_n = 0;
        while (!est_strobe && wait_n < 500) begin
            @(negedge clk);
            wait_n++;
        end
        chk(est_strobe, "R5", {tag, " strobe seen"}, est_strobe, 1);
        chk(est_fresh == fresh, "R5", {tag, " fresh"}, est_fresh, fresh);
        chk(half_mismatch == mm, "R3", {tag, " mismatch"}, half_mismatch, mm);
        chk(int'(frame_int) == exp_fi, "R2 R4", {tag, " frame_int"}, frame_int, exp_fi);
        chk(int'(frame_slope) == exp_fs, "R2 R4", {tag, " frame_slope"}, frame_slope, exp_fs);
        chk(avg_valid == (n_fresh >= 4), "R7", {tag, " avg_valid"}, avg_valid, n_fresh >= 4);
        chk(int'(avg_int) == (n_fresh >= 4 ? si >>> 2 : 0), "R7", {tag, " avg_int"},
            avg_int, n_fresh >= 4 ? si >>> 2 : 0);
        chk(int'(avg_slope) == (n_fresh >= 4 ? ss >>> 2 : 0), "R7", {tag, " avg_slope"},
            avg_slope, n_fresh >= 4 ? ss >>> 2 : 0);
        @(negedge clk);
        chk(!est_strobe, "R5", {tag, " strobe single cycle"}, est_strobe, 0);
        for (int z = 0; z < 2; z++) begin s_lo[z] = 0; s_hi[z] = 0; c_lo[z] = 0; c_hi[z] = 0; end
    endtask

    task automatic rand_frame();
        int roll, nl, nh, base, per;
        for (int z = 0; z < 2; z++) begin
            roll = $urandom_range(0, 7);
            nl = $urandom_range(1, 6);
            nh = (roll == 1) ? nl + 1 : nl;
            if (roll == 0) begin nl = 0; nh = 0; end
            base = z ? 20 : 1;
            per  = z ? 6 : 2;
            for (int p = 0; p < 2; p++) begin
                for (int k = 0; k < nl; k++) send(k, $urandom_range(0, 4095), 1'b0, base + p * per, z[0]);
                for (int k = 0; k < nh; k++) send(16 + k, $urandom_range(0, 4095), 1'b1, base + p * per, z[0]);
            end
        end
        close_frame("random");
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        for (int z = 0; z < 2; z++) begin s_lo[z] = 0; s_hi[z] = 0; c_lo[z] = 0; c_hi[z] = 0; end
        for (int k = 0; k < 32; k++) begin m_vld[k] = 0; m_ph[k] = 0; m_sym[k] = 0; m_amc[k] = 0; end
        for (int k = 0; k < 4; k++) begin h_i[k] = 0; h_s[k] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state.
        chk(!est_strobe && !est_fresh && !half_mismatch, "R8", "flags after reset",
            {est_strobe, est_fresh, half_mismatch}, 0);
        chk(frame_int == 0 && frame_slope == 0, "R8", "frame outputs after reset", frame_slope, 0);
        chk(avg_int == 0 && avg_slope == 0 && !avg_valid, "R8", "average outputs after reset",
            avg_slope, 0);

        // R1: wrap-around of the phase difference (2048 - 2047 = 1, 2047 - 2048 = -1).
        send(0, 2047, 1'b0, 1, 1'b0);
        send(16, 2048, 1'b1, 1, 1'b0);
        send(0, 2048, 1'b0, 3, 1'b0);
        send(16, 2047, 1'b1, 3, 1'b0);
        close_frame("R1 wrap");
        chk(frame_int == 0, "R1", "wrapped intercept", frame_int, 0);
        chk(frame_slope == -2, "R1", "wrapped slope", frame_slope, -2);

        // R1 R3 R4: wrong gap in the interleaved zone, adjacent zone alone usable.
        send(0, 100, 1'b0, 1, 1'b0);
        send(16, 200, 1'b1, 1, 1'b0);
        send(16, 260, 1'b1, 3, 1'b0);
        send(0, 900, 1'b0, 4, 1'b0);
        send(5, 4000, 1'b0, 20, 1'b1);
        send(21, 50, 1'b1, 20, 1'b1);
        send(5, 3990, 1'b0, 26, 1'b1);
        send(21, 75, 1'b1, 26, 1'b1);
        close_frame("R1 gap");
        chk(half_mismatch == 1'b1, "R3", "gap miss leaves halves unequal", half_mismatch, 1);

        // R1 R5: zone change on a slot gives no difference, outputs held.
        send(2, 300, 1'b0, 5, 1'b0);
        send(2, 700, 1'b0, 7, 1'b1);
        close_frame("R5 hold");

        // R6: a pair split across frame_end gives nothing.
        send(0, 10, 1'b0, 30, 1'b0);
        send(16, 10, 1'b1, 30, 1'b0);
        close_frame("R6 first");
        send(0, 400, 1'b0, 32, 1'b0);
        send(16, 800, 1'b1, 32, 1'b0);
        close_frame("R6 second");
        chk(est_fresh == 1'b0, "R6", "no pair across frames", est_fresh, 0);

        // Random frames with mixed zones, mismatches and empty zones.
        for (int f = 0; f < 24; f++) rand_frame();

        finish_run();
    end
endmodule